// File: doc/BRIEF.md
# Fan Tachometer Interrupt Gate

This block sits between the tachometer limit comparators of a hardware monitor and its interrupt pin. For each of three fans it takes a raw out-of-limit error flag. It decides whether that error may latch a sticky status bit. It then combines the latched status into one active-low interrupt output.

An error latches only under four conditions: its per-fan event enable is set, the fan is not disabled, the fan is tied to a valid PWM channel, and that channel's current duty byte is nonzero. Two 8-bit configuration registers on a simple register bus hold the enables and the fan-to-PWM mapping. A lock request freezes both registers until the next reset.

Software clears status bits through a write-one-to-clear port. Tach measurement, limit comparison and PWM generation are outside this block.

Top module: `fan_tach_irq_gate`

## Requirements
- R1: After reset the enable register reads 1Eh, the map register reads 24h, all status bits are 0 and `irq_n` is 1.
- R2: Enable register (address 0): bit 0 is the group enable, and bits 1..3 are the event enables for fans 1..3. Bit 4 always reads 1. Bits 7..5 read 0. Map register (address 1): bits 7..6 read 0. Writes to these reserved bits have no effect.
- R3: Once `lock_req` has been high for one cycle, writes to both registers are ignored, including a write in that same cycle. The lock stays in force after `lock_req` falls and is lifted only by reset.
- R4: A fan error sets that fan's status bit on the next clock edge only if the fan's event enable bit is 1.
- R5: The map register holds a 2-bit selector for each fan: fan 1 in bits 1:0, fan 2 in bits 3:2, fan 3 in bits 5:4. Code 00 selects PWM1, 01 selects PWM2 and 10 selects PWM3. An error is suppressed when the selected duty byte is 00h, and also when the code is 11.
- R6: An error from a fan whose `fan_off` bit is 1 never sets its status bit.
- R7: Status bits are sticky until cleared by `clr_we` with a 1 in the matching bit of `clr_mask`. A set and a clear of the same bit in the same cycle leave the bit set.
- R8: `irq_n` is 0 exactly when `irq_en_global` is 1, group enable is 1, and some status bit is 1 whose fan event enable is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| lock_req | input | 1 | Sets the sticky configuration lock |
| tach_err | input | 3 | Raw out-of-limit flag per fan |
| pwm_duty | input | 24 | Current duty bytes, PWM1 in bits 7:0 |
| fan_off | input | 3 | Per-fan disabled flag |
| irq_en_global | input | 1 | Global interrupt enable |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Write-one-to-clear mask |
| tach_sts | output | 3 | Sticky status bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A register write or a lock request takes effect at the next rising edge. Read data is combinational and is checked one time step after the edge. An error, or a clear, changes `tach_sts` at the edge on which it is presented. `irq_n` is a combinational function of status and configuration, so it is due in the same cycle as the status it reflects.

The bench drives every input just after a rising edge and samples outputs one time step later. Each expected value therefore belongs to exactly one edge. The mapping sweep covers all 64 selector combinations against all duty-zero and fan-off patterns.

// File: rtl/fti_pkg.sv
// Shared constants and types for the fan tach interrupt gate.
// Assumes an 8-bit register bus and 2-bit PWM selectors.
package fti_pkg;
    localparam int unsigned FTI_DATA_W  = 8;
    localparam int unsigned FTI_SEL_W   = 2;
    localparam int unsigned FTI_DUTY_W  = 8;
    localparam logic [7:0]  FTI_EN_RST  = 8'h1E;
    localparam logic [7:0]  FTI_MAP_RST = 8'h24;
    localparam int unsigned FTI_ONE_BIT = 4;
    typedef logic [FTI_SEL_W-1:0] fti_sel_t;
    localparam fti_sel_t    FTI_SEL_NONE = 2'b11;
endpackage

// File: rtl/fti_cfg_regs.sv
// Configuration registers: enable and fan-to-PWM map, plus the sticky lock.
// Assumes 2*NFAN < data width, so every map field fits in one byte.
module fti_cfg_regs
    import fti_pkg::*;
#(
    parameter int unsigned NFAN     = 3,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned EN_ADDR  = 0,
    parameter int unsigned MAP_ADDR = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lock_req,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [FTI_DATA_W-1:0]     wdata,
    output logic [FTI_DATA_W-1:0]     rdata,
    output logic                      grp_en,
    output logic [NFAN-1:0]           fan_en,
    output logic [NFAN*FTI_SEL_W-1:0] map_sel
);
    localparam int unsigned MAP_W = NFAN * FTI_SEL_W;

    logic             locked_q;
    logic             grp_q;
    logic [NFAN-1:0]  fen_q;
    logic [MAP_W-1:0] map_q;
    logic             wr_ok;
    logic             wdata_unused;

    assign wr_ok        = wr_en && !locked_q && !lock_req;
    assign wdata_unused = ^wdata[FTI_DATA_W-1:MAP_W];

    // Lock flag: set by request, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked_q <= 1'b0;
        else if (lock_req) locked_q <= 1'b1;
    end

    // Enable register storage; reserved bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= FTI_EN_RST[0];
            fen_q <= FTI_EN_RST[NFAN:1];
        end else if (wr_ok && addr == ADDR_W'(EN_ADDR)) begin
            grp_q <= wdata[0];
            fen_q <= wdata[NFAN:1];
        end
    end

    // Map register storage; reserved upper bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            map_q <= FTI_MAP_RST[MAP_W-1:0];
        else if (wr_ok && addr == ADDR_W'(MAP_ADDR))
            map_q <= wdata[MAP_W-1:0];
    end

    // Read mux; reserved bits read 0 except the fixed-one enable bit.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(EN_ADDR)) begin
            rdata[0]           = grp_q;
            rdata[NFAN:1]      = fen_q;
            rdata[FTI_ONE_BIT] = 1'b1;
        end else if (addr == ADDR_W'(MAP_ADDR)) begin
            rdata[MAP_W-1:0] = map_q;
        end
    end

    assign grp_en  = grp_q;
    assign fan_en  = fen_q;
    assign map_sel = map_q;

    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q);
    a_r3_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> ($stable(grp_q) && $stable(fen_q) && $stable(map_q)));
endmodule

// File: rtl/fti_qualify.sv
// Per-fan error qualifier: passes an error only when the fan is enabled,
// not disabled, and mapped to a PWM channel with nonzero duty.
// Assumes NPWM < 2**selector width, so the all-ones code means no mapping.
module fti_qualify
    import fti_pkg::*;
#(
    parameter int unsigned NFAN = 3,
    parameter int unsigned NPWM = 3
) (
    input  logic [NFAN-1:0]            err,
    input  logic [NFAN-1:0]            fan_en,
    input  logic [NFAN-1:0]            fan_off,
    input  logic [NFAN*FTI_SEL_W-1:0]  map_sel,
    input  logic [NPWM*FTI_DUTY_W-1:0] duty,
    output logic [NFAN-1:0]            qual
);
    for (genvar i = 0; i < NFAN; i++) begin : g_fan
        fti_sel_t sel;
        logic     running;
        assign sel = map_sel[i*FTI_SEL_W +: FTI_SEL_W];

        // Pick the mapped channel's duty; an unmapped code never matches.
        always_comb begin
            running = 1'b0;
            for (int p = 0; p < NPWM; p++)
                if (sel == FTI_SEL_W'(p))
                    running = |duty[p*FTI_DUTY_W +: FTI_DUTY_W];
        end

        assign qual[i] = err[i] && fan_en[i] && !fan_off[i] && running;
    end
endmodule

// File: rtl/fti_status.sv
// Sticky status bits with write-one-to-clear; a set outranks a clear.
module fti_status #(
    parameter int unsigned NFAN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFAN-1:0] qual,
    input  logic            clr_we,
    input  logic [NFAN-1:0] clr_mask,
    output logic [NFAN-1:0] sts
);
    logic [NFAN-1:0] sts_q;
    logic [NFAN-1:0] keep;

    assign keep = clr_we ? ~clr_mask : '1;

    // Status update: hold unless cleared, then OR in new qualified errors.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & keep) | qual;
    end

    assign sts = sts_q;

    a_r4_set_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(qual)) == '0));
    a_r7_no_spont_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
endmodule

// File: rtl/fan_tach_irq_gate.sv
// Top level: configuration, qualification, sticky status and interrupt pin.
// Assumes all inputs are synchronous to clk.
module fan_tach_irq_gate
    import fti_pkg::*;
#(
    parameter int unsigned NFAN   = 3,
    parameter int unsigned NPWM   = 3,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [FTI_DATA_W-1:0]      reg_wdata,
    output logic [FTI_DATA_W-1:0]      reg_rdata,
    input  logic                       lock_req,
    input  logic [NFAN-1:0]            tach_err,
    input  logic [NPWM*FTI_DUTY_W-1:0] pwm_duty,
    input  logic [NFAN-1:0]            fan_off,
    input  logic                       irq_en_global,
    input  logic                       clr_we,
    input  logic [NFAN-1:0]            clr_mask,
    output logic [NFAN-1:0]            tach_sts,
    output logic                       irq_n
);
    logic                      grp_en;
    logic [NFAN-1:0]           fan_en;
    logic [NFAN*FTI_SEL_W-1:0] map_sel;
    logic [NFAN-1:0]           qual;

    fti_cfg_regs #(.NFAN(NFAN), .ADDR_W(ADDR_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .lock_req(lock_req), .wr_en(reg_we),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .grp_en(grp_en), .fan_en(fan_en), .map_sel(map_sel)
    );

    fti_qualify #(.NFAN(NFAN), .NPWM(NPWM)) i_qual (
        .err(tach_err), .fan_en(fan_en), .fan_off(fan_off),
        .map_sel(map_sel), .duty(pwm_duty), .qual(qual)
    );

    fti_status #(.NFAN(NFAN)) i_sts (
        .clk(clk), .rst_n(rst_n), .qual(qual), .clr_we(clr_we),
        .clr_mask(clr_mask), .sts(tach_sts)
    );

    // Interrupt pin: active low when any enabled status is pending.
    always_comb begin
        irq_n = !(irq_en_global && grp_en && |(tach_sts & fan_en));
    end

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (irq_en_global && grp_en && (tach_sts != '0)));
    a_r6_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (qual & fan_off) == '0);
endmodule

// File: tb/test_fan_tach_irq_gate.sv
`timescale 1ns/1ps
module test_fan_tach_irq_gate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        lock_req;
    logic [2:0]  tach_err;
    logic [23:0] pwm_duty;
    logic [2:0]  fan_off;
    logic        irq_en_global;
    logic        clr_we;
    logic [2:0]  clr_mask;
    logic [2:0]  tach_sts;
    logic        irq_n;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    fan_tach_irq_gate i_fan_tach_irq_gate (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_req(lock_req),
        .tach_err(tach_err), .pwm_duty(pwm_duty), .fan_off(fan_off),
        .irq_en_global(irq_en_global), .clr_we(clr_we), .clr_mask(clr_mask),
        .tach_sts(tach_sts), .irq_n(irq_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_mask = 3'b111;
        tick();
        clr_we = 1'b0; clr_mask = 3'b000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        reg_we = 0; reg_addr = 0; reg_wdata = 0; lock_req = 0;
        tach_err = 0; pwm_duty = 24'h010101; fan_off = 0;
        irq_en_global = 0; clr_we = 0; clr_mask = 0;
        #1;
        do_reset();

        // R1: reset state
        rd_chk("R1 en", 8'd0, 8'h1E);
        rd_chk("R1 map", 8'd1, 8'h24);
        chk("R1 sts", {5'b0, tach_sts}, 8'h00);
        chk("R1 irq", {7'b0, irq_n}, 8'h01);

        // R2: reserved bits
        wr(8'd0, 8'hFF); rd_chk("R2 en ones", 8'd0, 8'h1F);
        wr(8'd0, 8'h00); rd_chk("R2 en zeros", 8'd0, 8'h10);
        wr(8'd1, 8'hFF); rd_chk("R2 map ones", 8'd1, 8'h3F);
        wr(8'd1, 8'h00); rd_chk("R2 map zeros", 8'd1, 8'h00);

        // R5/R6 sweep with all fans enabled, global on
        wr(8'd0, 8'h0F);
        irq_en_global = 1'b1;
        for (int m = 0; m < 64; m++) begin
            wr(8'd1, 8'(m));
            for (int dz = 0; dz < 8; dz++) begin
                for (int off = 0; off < 8; off++) begin
                    logic [2:0] exp;
                    pwm_duty[7:0]   = dz[0] ? 8'h01 : 8'h00;
                    pwm_duty[15:8]  = dz[1] ? 8'h80 : 8'h00;
                    pwm_duty[23:16] = dz[2] ? 8'hFF : 8'h00;
                    fan_off = 3'(off);
                    for (int f = 0; f < 3; f++) begin
                        int s;
                        s = (m >> (2 * f)) & 3;
                        exp[f] = (s != 3) && dz[s] && !off[f];
                    end
                    tach_err = 3'b111;
                    tick();
                    tach_err = 3'b000;
                    chk("R5 R6 qualify", {5'b0, tach_sts}, {5'b0, exp});
                    chk("R8 irq sweep", {7'b0, irq_n}, {7'b0, ~|exp});
                    clear_all();
                end
            end
        end

        // R4: per-fan event enables
        wr(8'd1, 8'h24);
        pwm_duty = 24'h050505; fan_off = 0;
        for (int fe = 0; fe < 8; fe++) begin
            wr(8'd0, {4'b0, 3'(fe), 1'b1});
            tach_err = 3'b111;
            tick();
            tach_err = 3'b000;
            chk("R4 event enable", {5'b0, tach_sts}, 8'(fe));
            clear_all();
        end

        // R7: sticky, W1C, set wins
        wr(8'd0, 8'h0F);
        tach_err = 3'b111; tick(); tach_err = 0;
        tick(); tick(); tick();
        chk("R7 sticky", {5'b0, tach_sts}, 8'h07);
        clr_we = 1; clr_mask = 3'b010; tick(); clr_we = 0; clr_mask = 0;
        chk("R7 w1c", {5'b0, tach_sts}, 8'h05);
        clr_mask = 3'b001; tick(); clr_mask = 0;
        chk("R7 mask without strobe", {5'b0, tach_sts}, 8'h05);
        tach_err = 3'b001; clr_we = 1; clr_mask = 3'b001; tick();
        tach_err = 0; clr_we = 0; clr_mask = 0;
        chk("R7 set wins", {5'b0, tach_sts}, 8'h05);
        clear_all();
        chk("R7 clear all", {5'b0, tach_sts}, 8'h00);

        // R8: interrupt combination sweep
        for (int pat = 1; pat < 8; pat++) begin
            for (int e = 0; e < 16; e++) begin
                for (int g = 0; g < 2; g++) begin
                    logic expn;
                    wr(8'd0, 8'h0F);
                    tach_err = 3'(pat); tick(); tach_err = 0;
                    wr(8'd0, 8'(e));
                    irq_en_global = g[0];
                    #1;
                    expn = !(g[0] && e[0] && |(3'(pat) & 3'(e >> 1)));
                    chk("R8 irq", {7'b0, irq_n}, {7'b0, expn});
                    clear_all();
                end
            end
        end

        // R3: lock behaviour
        wr(8'd0, 8'h0B); wr(8'd1, 8'h12);
        reg_we = 1; reg_addr = 8'd0; reg_wdata = 8'h01; lock_req = 1;
        tick();
        reg_we = 0; lock_req = 0;
        rd_chk("R3 same-cycle write", 8'd0, 8'h1B);
        wr(8'd0, 8'h00); rd_chk("R3 en locked", 8'd0, 8'h1B);
        wr(8'd1, 8'h00); rd_chk("R3 map locked", 8'd1, 8'h12);
        tick(); tick();
        wr(8'd1, 8'h3F); rd_chk("R3 still locked", 8'd1, 8'h12);
        do_reset();
        rd_chk("R3 reset defaults", 8'd0, 8'h1E);
        wr(8'd1, 8'h06); rd_chk("R3 unlocked by reset", 8'd1, 8'h06);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule